// File: doc/BRIEF.md
# RTC Status Flag and Write Synchronization Handshake

This block holds the status flags that sit between a slow real-time-clock domain and a fast bus domain. It keeps a ready flag that follows the updates of the seconds counter. It keeps a busy flag that covers the transfer of each software register write into the slow domain. It also holds two sticky alarm flags, one for the sub-second alarm and one for the time-of-day alarm, and either of them raises a wake request. The seconds counter and the alarm comparators are outside this block. They reach it only as single-cycle strobes in the slow domain.

Slow-domain events enter the bus domain as toggles through two-flop synchronizers and come out as one-cycle pulses. All flags and the interrupt live in the bus domain. A software write is latched in the bus domain and announced with a request toggle. The slow side sees it as a one-cycle write strobe and sends back an acknowledge toggle. Busy stays high until that acknowledge has crossed back.

Top module: `rtc_sync_status`

## Requirements
- R1: After reset, rdy_o, busy_o, ss_flag_o, tod_flag_o, rdy_irq_o, wake_o and rtc_wr_stb_o are all 0.
- R2: A sec_due_i strobe means the seconds register updates on the next slow edge. Ready is cleared for the slow cycle before that update and set again once the update has been made. In the bus domain, each change is visible within 3 bus clock edges of the slow edge that causes it.
- R3: A one-cycle rdy_clr_i pulse clears rdy_o at the next bus edge.
- R4: When a hardware set of a flag and a software clear of the same flag fall on the same bus cycle, the flag ends that cycle set.
- R5: rdy_irq_o is high exactly while rdy_o is 1 and rdy_ie_i is 1.
- R6: ss_alarm_i sets ss_flag_o and tod_alarm_i sets tod_flag_o. Each flag stays set until its own clear input (ss_clr_i or tod_clr_i) is pulsed. wake_o is high while either flag is set.
- R7: A wr_i accepted while busy_o is 0 raises busy_o at the next bus edge. It produces exactly one one-slow-cycle rtc_wr_stb_o carrying wr_data_i. busy_o falls only after the acknowledge has come back to the bus domain.
- R8: A wr_i while busy_o is 1 is ignored. busy_o stays 1, no extra strobe is produced, and the data of the pending write is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rtc_clk_i | input | 1 | Slow RTC clock |
| rst_ni | input | 1 | Active-low asynchronous reset, both domains |
| sec_due_i | input | 1 | Slow strobe: seconds register updates next slow edge |
| ss_alarm_i | input | 1 | Slow strobe: sub-second alarm event |
| tod_alarm_i | input | 1 | Slow strobe: time-of-day alarm event |
| wr_i | input | 1 | Bus strobe: software register write |
| wr_data_i | input | DATA_W | Write data |
| rdy_clr_i | input | 1 | Bus strobe: software clear of ready |
| ss_clr_i | input | 1 | Bus strobe: clear sub-second alarm flag |
| tod_clr_i | input | 1 | Bus strobe: clear time-of-day alarm flag |
| rdy_ie_i | input | 1 | Ready interrupt enable |
| rdy_o | output | 1 | Ready flag |
| busy_o | output | 1 | Write synchronization in progress |
| ss_flag_o | output | 1 | Sub-second alarm pending |
| tod_flag_o | output | 1 | Time-of-day alarm pending |
| rdy_irq_o | output | 1 | Ready interrupt |
| wake_o | output | 1 | Wake request |
| rtc_wr_stb_o | output | 1 | Slow-domain write strobe |
| rtc_wr_data_o | output | DATA_W | Slow-domain write data |

## Verification
A slow-domain event is due in the bus domain no later than three bus edges after the slow edge that makes it. The bench therefore samples flags five bus cycles after that slow edge, which is still well before the next slow edge. That window separates the clear and the set of the ready sequence. Software clears and busy's rise are due one bus edge after the strobe and are sampled at the following falling edge. Write strobes arrive a variable number of slow cycles later, so a scoreboard queue matches them whenever they appear, and busy's fall is polled against a bounded timeout.

// File: rtl/rtc_hs_pkg.sv
package rtc_hs_pkg;
  localparam int EV_N      = 4;
  localparam int EV_RDY_CLR = 0;
  localparam int EV_RDY_SET = 1;
  localparam int EV_SS      = 2;
  localparam int EV_TOD     = 3;
  localparam int FL_N      = 3;
  localparam int FL_RDY    = 0;
  localparam int FL_SS     = 1;
  localparam int FL_TOD    = 2;
endpackage

// File: rtl/rtc_hs_sync.sv
module rtc_hs_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] r;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) r <= '0;
    else         r <= {r[STAGES-2:0], d_i};
  end
  assign q_o = r[STAGES-1];
endmodule

// File: rtl/rtc_hs_evx.sv
// slow-domain strobes -> bus-domain single-cycle pulses
module rtc_hs_evx #(
  parameter int N      = 4,
  parameter int STAGES = 2
) (
  input  logic         rtc_clk_i,
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] ev_i,
  output logic [N-1:0] pulse_o
);
  for (genvar g = 0; g < N; g++) begin : g_ev
    logic tgl, tgl_s, tgl_d;
    always_ff @(posedge rtc_clk_i or negedge rst_ni) begin
      if (!rst_ni)      tgl <= 1'b0;
      else if (ev_i[g]) tgl <= ~tgl;
    end
    rtc_hs_sync #(.STAGES(STAGES)) u_sync (
      .clk_i(clk_i), .rst_ni(rst_ni), .d_i(tgl), .q_o(tgl_s)
    );
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) tgl_d <= 1'b0;
      else         tgl_d <= tgl_s;
    end
    assign pulse_o[g] = tgl_s ^ tgl_d;

    assert_pulse_single_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      pulse_o[g] |=> !pulse_o[g]);
  end
endmodule

// File: rtl/rtc_hs_wrx.sv
module rtc_hs_wrx #(
  parameter int DATA_W = 32,
  parameter int STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rtc_clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic              busy_o,
  output logic              stb_o,
  output logic [DATA_W-1:0] data_o
);
  logic req_tgl, ack_s, req_s, ack_tgl, accept;
  logic [DATA_W-1:0] data_q;

  assign busy_o = req_tgl ^ ack_s;
  assign accept = wr_i & ~busy_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_tgl <= 1'b0;
      data_q  <= '0;
    end else if (accept) begin
      req_tgl <= ~req_tgl;
      data_q  <= wr_data_i;
    end
  end

  rtc_hs_sync #(.STAGES(STAGES)) u_req_sync (
    .clk_i(rtc_clk_i), .rst_ni(rst_ni), .d_i(req_tgl), .q_o(req_s)
  );

  always_ff @(posedge rtc_clk_i or negedge rst_ni) begin
    if (!rst_ni) ack_tgl <= 1'b0;
    else         ack_tgl <= req_s;
  end
  assign stb_o  = req_s ^ ack_tgl;
  assign data_o = data_q;   // held stable while busy

  rtc_hs_sync #(.STAGES(STAGES)) u_ack_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(ack_tgl), .q_o(ack_s)
  );

  assert_busy_rise_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !busy_o) |=> busy_o);
  assert_wr_ignored_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && busy_o) |=> $stable(data_q));
  assert_single_stb_R7: assert property (@(posedge rtc_clk_i) disable iff (!rst_ni)
    stb_o |=> !stb_o);
endmodule

// File: rtl/rtc_hs_flag.sv
module rtc_hs_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    flag_o <= 1'b0;
    else if (set_i) flag_o <= 1'b1;   // set beats clear
    else if (clr_i) flag_o <= 1'b0;
  end

  assert_set_wins_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> flag_o);
  // covers R3 and R6 clears
  assert_clear_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !set_i) |=> !flag_o);
endmodule

// File: rtl/rtc_sync_status.sv
module rtc_sync_status
  import rtc_hs_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rtc_clk_i,
  input  logic              rst_ni,
  input  logic              sec_due_i,
  input  logic              ss_alarm_i,
  input  logic              tod_alarm_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              rdy_clr_i,
  input  logic              ss_clr_i,
  input  logic              tod_clr_i,
  input  logic              rdy_ie_i,
  output logic              rdy_o,
  output logic              busy_o,
  output logic              ss_flag_o,
  output logic              tod_flag_o,
  output logic              rdy_irq_o,
  output logic              wake_o,
  output logic              rtc_wr_stb_o,
  output logic [DATA_W-1:0] rtc_wr_data_o
);
  logic            upd_q;
  logic [EV_N-1:0] ev, pulse;
  logic [FL_N-1:0] fl_set, fl_clr, flag;

  // upd_q marks the slow edge on which the seconds register updates
  always_ff @(posedge rtc_clk_i or negedge rst_ni) begin
    if (!rst_ni) upd_q <= 1'b0;
    else         upd_q <= sec_due_i;
  end

  always_comb begin
    ev             = '0;
    ev[EV_RDY_CLR] = sec_due_i;
    ev[EV_RDY_SET] = upd_q;
    ev[EV_SS]      = ss_alarm_i;
    ev[EV_TOD]     = tod_alarm_i;
  end

  rtc_hs_evx #(.N(EV_N), .STAGES(STAGES)) u_evx (
    .rtc_clk_i(rtc_clk_i), .clk_i(clk_i), .rst_ni(rst_ni),
    .ev_i(ev), .pulse_o(pulse)
  );

  always_comb begin
    fl_set         = '0;
    fl_clr         = '0;
    fl_set[FL_RDY] = pulse[EV_RDY_SET];
    fl_clr[FL_RDY] = pulse[EV_RDY_CLR] | rdy_clr_i;
    fl_set[FL_SS]  = pulse[EV_SS];
    fl_clr[FL_SS]  = ss_clr_i;
    fl_set[FL_TOD] = pulse[EV_TOD];
    fl_clr[FL_TOD] = tod_clr_i;
  end

  for (genvar g = 0; g < FL_N; g++) begin : g_flag
    rtc_hs_flag u_flag (
      .clk_i(clk_i), .rst_ni(rst_ni),
      .set_i(fl_set[g]), .clr_i(fl_clr[g]), .flag_o(flag[g])
    );
  end

  rtc_hs_wrx #(.DATA_W(DATA_W), .STAGES(STAGES)) u_wrx (
    .clk_i(clk_i), .rtc_clk_i(rtc_clk_i), .rst_ni(rst_ni),
    .wr_i(wr_i), .wr_data_i(wr_data_i), .busy_o(busy_o),
    .stb_o(rtc_wr_stb_o), .data_o(rtc_wr_data_o)
  );

  assign rdy_o      = flag[FL_RDY];
  assign ss_flag_o  = flag[FL_SS];
  assign tod_flag_o = flag[FL_TOD];
  assign rdy_irq_o  = rdy_o & rdy_ie_i;
  assign wake_o     = ss_flag_o | tod_flag_o;

  assert_alarm_sticky_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ss_flag_o && !ss_clr_i) |=> ss_flag_o);
  assert_due_clears_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pulse[EV_RDY_CLR] && !pulse[EV_RDY_SET]) |=> !rdy_o);
endmodule

// File: tb/rtc_sync_status_tb.sv
module rtc_sync_status_tb;
  localparam int DW = 32;
  logic clk = 0, rtc_clk = 0, rst_n = 0;
  logic sec_due = 0, ss_al = 0, tod_al = 0, wr = 0;
  logic [DW-1:0] wdata = '0;
  logic rdy_clr = 0, ss_clr = 0, tod_clr = 0, ie = 0;
  logic rdy, busy, ssf, todf, irq, wake, stb;
  logic [DW-1:0] rdata;
  int errors = 0, checks = 0;
  bit done = 0;
  logic [DW-1:0] exp_q[$];

  always #10 clk = ~clk;
  always #150 rtc_clk = ~rtc_clk;

  rtc_sync_status #(.DATA_W(DW)) u_dut (
    .clk_i(clk), .rtc_clk_i(rtc_clk), .rst_ni(rst_n),
    .sec_due_i(sec_due), .ss_alarm_i(ss_al), .tod_alarm_i(tod_al),
    .wr_i(wr), .wr_data_i(wdata), .rdy_clr_i(rdy_clr), .ss_clr_i(ss_clr),
    .tod_clr_i(tod_clr), .rdy_ie_i(ie), .rdy_o(rdy), .busy_o(busy),
    .ss_flag_o(ssf), .tod_flag_o(todf), .rdy_irq_o(irq), .wake_o(wake),
    .rtc_wr_stb_o(stb), .rtc_wr_data_o(rdata)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: pops expected write data on each slow strobe
  always @(negedge rtc_clk) begin
    if (rst_n && stb) begin
      if (exp_q.size() == 0) check(0, "R8 unexpected strobe", rdata, 0);
      else begin
        logic [DW-1:0] e;
        e = exp_q.pop_front();
        check(rdata == e, "R7 strobe data", rdata, e);
      end
    end
  end

  task automatic slow_pulse(ref logic s);
    @(negedge rtc_clk); s = 1;
    @(negedge rtc_clk); s = 0;
  endtask

  task automatic settle();
    repeat (5) @(negedge clk);
  endtask

  task automatic bus_pulse(ref logic s);
    @(negedge clk); s = 1;
    @(negedge clk); s = 0;
  endtask

  task automatic do_write(input logic [DW-1:0] d);
    @(negedge clk); wr = 1; wdata = d;
    if (!busy) exp_q.push_back(d);
    @(negedge clk); wr = 0;
  endtask

  task automatic wait_idle(input string req);
    int n = 0;
    while (busy && n < 400) begin @(negedge clk); n++; end
    check(!busy, req, busy, 0);
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=1 expected=0");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check({rdy, busy, ssf, todf, irq, wake, stb} == 7'b0, "R1 reset",
          {rdy, busy, ssf, todf, irq, wake, stb}, 0);
    rst_n = 1;
    repeat (3) @(negedge clk);
    check({rdy, busy, ssf, todf, irq, wake, stb} == 7'b0, "R1 after release",
          {rdy, busy, ssf, todf, irq, wake, stb}, 0);

    // R2: first update brings ready up
    @(negedge rtc_clk); sec_due = 1;
    @(posedge rtc_clk); @(negedge rtc_clk); sec_due = 0;
    @(posedge rtc_clk); settle();
    check(rdy == 1, "R2 set after update", rdy, 1);
    // R2: cleared the slow cycle before the update, set after it
    @(negedge rtc_clk); sec_due = 1;
    @(posedge rtc_clk); settle();
    check(rdy == 0, "R2 cleared before update", rdy, 0);
    @(negedge rtc_clk); sec_due = 0;
    @(posedge rtc_clk); settle();
    check(rdy == 1, "R2 set again", rdy, 1);

    // R5 interrupt gating
    @(negedge clk); ie = 1; @(negedge clk);
    check(irq == 1, "R5 irq with enable", irq, 1);
    ie = 0; @(negedge clk);
    check(irq == 0, "R5 irq masked", irq, 0);
    ie = 1;

    // R3 software clear
    bus_pulse(rdy_clr);
    check(rdy == 0, "R3 sw clear", rdy, 0);
    check(irq == 0, "R5 irq drops with ready", irq, 0);

    // R4: clear held across the set pulse; set must win once
    begin
      bit seen = 0;
      @(negedge clk); rdy_clr = 1;
      @(negedge rtc_clk); sec_due = 1;
      @(negedge rtc_clk); sec_due = 0;
      @(posedge rtc_clk);
      for (int i = 0; i < 10; i++) begin @(negedge clk); if (rdy) seen = 1; end
      check(seen, "R4 set wins over clear", seen, 1);
      rdy_clr = 0;
    end

    // R6 alarms
    slow_pulse(ss_al); settle();
    check(ssf == 1 && todf == 0, "R6 sub-second set", {ssf, todf}, 2'b10);
    check(wake == 1, "R6 wake", wake, 1);
    repeat (40) @(negedge clk);
    check(ssf == 1, "R6 sticky", ssf, 1);
    slow_pulse(tod_al); settle();
    check(todf == 1, "R6 time-of-day set", todf, 1);
    bus_pulse(ss_clr);
    check(ssf == 0 && wake == 1, "R6 ss clear keeps wake", {ssf, wake}, 2'b01);
    bus_pulse(tod_clr);
    check(todf == 0 && wake == 0, "R6 all clear", {todf, wake}, 0);

    // R7 write transfer
    do_write(32'hA5A5_0001);
    check(busy == 1, "R7 busy rises", busy, 1);
    wait_idle("R7 busy falls");
    repeat (40) @(negedge clk);
    check(exp_q.size() == 0, "R7 strobe delivered", exp_q.size(), 0);

    // R8 write while busy
    do_write(32'h1234_5678);
    do_write(32'hDEAD_BEEF);
    check(busy == 1, "R8 busy held", busy, 1);
    check(rdata == 32'h1234_5678, "R8 pending data kept", rdata, 32'h1234_5678);
    wait_idle("R8 busy falls");
    repeat (60) @(negedge clk);
    check(exp_q.size() == 0, "R8 single strobe", exp_q.size(), 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule